// File: doc/BRIEF.md
# Dual Interval Timer with Status Port

This block gives a processor two reloadable interval timers behind a byte-wide register window. Software reaches it through an address/data port pair. It first writes a register number to an address port. It then writes the value to the matching data port. There are two independent banks, each with its own remembered address. Only bank 0 decodes the timer registers. Timer A is a 10-bit up-counter and timer B is an 8-bit up-counter. Both advance on a shared, externally prescaled tick strobe.

A control register starts or stops each timer and chooses whether an overflow latches a status flag. The same register clears either flag and holds a 2-bit channel-mode field, which the block drives out for a neighbouring channel. The status byte is presented on the read bus at all times, so a read of any port address returns it. The status byte carries a busy bit that stays high briefly after every data write. The interrupt output is raised while either flag is set.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset the read bus is 0x00, the interrupt output is low, the channel-mode output is 0, both timers are stopped and both flags are clear.
- R2: portSel bit 0 = 0 writes the register number and portSel bit 0 = 1 writes data. portSel bit 1 selects the bank. A data write lands in the register last numbered in the same bank. Data writes to bank 1 change no timer state.
- R3: Timer A's reload is {reg 0x24[7:0], reg 0x25[1:0]}. Once started from reload R it overflows on tick number 1024−R. It then reloads R and keeps counting.
- R4: Timer B's reload is reg 0x26[7:0]. Once started from reload R it overflows on tick number 256−R. It then reloads R and keeps counting.
- R5: In reg 0x27, bit 0 = 1 runs timer A and bit 1 = 1 runs timer B. A stopped timer ignores ticks and sits at its reload value, so a later start counts from the reload.
- R6: In reg 0x27, bit 2 (timer A) and bit 3 (timer B) let an overflow set that timer's flag. With the bit at 0, overflows leave the flag unchanged.
- R7: Writing reg 0x27 with bit 4 = 1 clears flag A and with bit 5 = 1 clears flag B. A 0 in either bit leaves the flag alone. A clear that coincides with an overflow of the same timer leaves the flag low.
- R8: The read byte is {busy, 5'b0, flagB, flagA}.
- R9: Busy reads 1 for exactly BUSY_CYCLES clock cycles after the edge that takes any data write, in either bank, and 0 otherwise.
- R10: The interrupt output equals flagA OR flagB.
- R11: The channel-mode output is reg 0x27 bits 7:6 as last written. It changes only on a write of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle prescaled count strobe for both timers |
| wrEn | input | 1 | Write strobe for the port selected by portSel |
| portSel | input | 2 | Bit 0: 0 address, 1 data; bit 1: bank |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Status byte, valid for any port read |
| irqOut | output | 1 | Active-high interrupt, OR of the two flags |
| chanMode | output | 2 | Stored channel-mode field |

## Verification
The properties assume that tickIn and wrEn are single-cycle strobes sampled on the rising clock. They also assume that flags only rise in a cycle where a tick was present. The checker rebuilds the bank-0 register number from the port writes, so it assumes no write happens during reset. The stimulus drives every input on the falling edge, keeps writes and ticks to one cycle each, and holds reset through several edges. The only place where a tick and a control write share a cycle is the deliberate clear-versus-overflow case.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] REG_TA_HI = 8'h24;
  localparam logic [DATA_W-1:0] REG_TA_LO = 8'h25;
  localparam logic [DATA_W-1:0] REG_TB    = 8'h26;
  localparam logic [DATA_W-1:0] REG_CTRL  = 8'h27;

  typedef struct packed {
    logic wrRelAHi;
    logic wrRelALo;
    logic wrRelB;
    logic wrCtrl;
  } regStrobe_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] count;

  assign wrap = run && tick && (count == MAXV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!run) begin
      count <= reload;
    end else if (tick) begin
      count <= (count == MAXV) ? reload : count + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        portSel,
  input  logic [DATA_W-1:0] wrData,
  output regStrobe_t        strobe,
  output logic              busy
);
  localparam int NUM_BANKS = 2;
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

  logic [DATA_W-1:0] addrLatch [NUM_BANKS];
  logic [BW-1:0]     busyCnt;
  logic              dataWr;
  logic              bank0Data;

  assign dataWr    = wrEn && portSel[0];
  assign bank0Data = dataWr && !portSel[1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrLatch[b] <= '0;
      end else if (wrEn && !portSel[0] && (int'(portSel[1]) == b)) begin
        addrLatch[b] <= wrData;
      end
    end
  end

  always_comb begin
    strobe.wrRelAHi = bank0Data && (addrLatch[0] == REG_TA_HI);
    strobe.wrRelALo = bank0Data && (addrLatch[0] == REG_TA_LO);
    strobe.wrRelB   = bank0Data && (addrLatch[0] == REG_TB);
    strobe.wrCtrl   = bank0Data && (addrLatch[0] == REG_CTRL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (dataWr) begin
      busyCnt <= BUSY_LOAD;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int A_WIDTH = 10,
  parameter int B_WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              flagA,
  output logic              flagB,
  output logic [1:0]        chanMode
);
  localparam int A_LO_W = A_WIDTH - DATA_W;

  logic [DATA_W-1:0]  relAHi;
  logic [A_LO_W-1:0]  relALo;
  logic [B_WIDTH-1:0] relB;
  logic               runA, runB, enA, enB;
  logic               wrapA, wrapB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relAHi   <= '0;
      relALo   <= '0;
      relB     <= '0;
      runA     <= 1'b0;
      runB     <= 1'b0;
      enA      <= 1'b0;
      enB      <= 1'b0;
      chanMode <= 2'd0;
    end else begin
      if (strobe.wrRelAHi) relAHi <= wrData;
      if (strobe.wrRelALo) relALo <= wrData[A_LO_W-1:0];
      if (strobe.wrRelB)   relB   <= wrData[B_WIDTH-1:0];
      if (strobe.wrCtrl) begin
        runA     <= wrData[0];
        runB     <= wrData[1];
        enA      <= wrData[2];
        enB      <= wrData[3];
        chanMode <= wrData[7:6];
      end
    end
  end

  tmr_counter #(.W(A_WIDTH)) u_cntA (
    .clk(clk), .rstN(rstN), .run(runA), .tick(tickIn),
    .reload({relAHi, relALo}), .wrap(wrapA)
  );

  tmr_counter #(.W(B_WIDTH)) u_cntB (
    .clk(clk), .rstN(rstN), .run(runB), .tick(tickIn),
    .reload(relB), .wrap(wrapB)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
    end else begin
      if (strobe.wrCtrl && wrData[4]) flagA <= 1'b0;
      else if (wrapA && enA)          flagA <= 1'b1;
      if (strobe.wrCtrl && wrData[5]) flagB <= 1'b0;
      else if (wrapB && enB)          flagB <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tmr_pkg::*;
#(
  parameter int A_WIDTH     = 10,
  parameter int B_WIDTH     = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       wrEn,
  input  logic [1:0] portSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqOut,
  output logic [1:0] chanMode
);
  regStrobe_t strobe;
  logic       busy, flagA, flagB;

  tmr_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .portSel(portSel),
    .wrData(wrData), .strobe(strobe), .busy(busy)
  );

  tmr_datapath #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strobe(strobe),
    .wrData(wrData), .flagA(flagA), .flagB(flagB), .chanMode(chanMode)
  );

  assign rdData = {busy, 5'b00000, flagB, flagA};
  assign irqOut = flagA | flagB;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickIn,
  input logic       wrEn,
  input logic [1:0] portSel,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       irqOut,
  input logic [1:0] chanMode
);
  logic [7:0] shadowAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowAddr <= '0;
    else if (wrEn && portSel == 2'b00) shadowAddr <= wrData;
  end

  p_zero_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6:2] == 5'b0);

  p_irq_or_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (rdData[1] | rdData[0]));

  p_busy_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel[0]) |=> rdData[7]);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'b01 && shadowAddr == 8'h27 && wrData[4]) |=> !rdData[0]);

  p_flag_needs_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[0]) |-> $past(tickIn));

  p_mode_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portSel == 2'b01 && shadowAddr == 8'h27) |=> $stable(chanMode));
endmodule

bind tick_timer_pair tmr_checker u_chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .portSel(portSel),
  .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .chanMode(chanMode)
);

// File: tb/tick_timer_pair_tb.sv
`timescale 1ns/1ps
module tick_timer_pair_tb_top;
  localparam int BUSY = 4;

  logic       clk = 0;
  logic       rstN = 0;
  logic       tickIn = 0;
  logic       wrEn = 0;
  logic [1:0] portSel = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic       irqOut;
  logic [1:0] chanMode;

  int nCmp = 0;
  int nBad = 0;
  bit cmpOn = 0;

  always #4 clk = ~clk;

  tick_timer_pair #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .chanMode(chanMode)
  );

  // behavioural reference state
  int       busyM, cntA, cntB;
  bit [7:0] lat0, lat1, relAHi, relB;
  bit [1:0] relALo, modeM;
  bit       runA, runB, enA, enB, fA, fB;

  always @(posedge clk) begin
    int  relA, nA, nB;
    bit  wrapA, wrapB, dataW, ctrlW;
    if (!rstN) begin
      busyM = 0; cntA = 0; cntB = 0; lat0 = 0; lat1 = 0; relAHi = 0; relB = 0;
      relALo = 0; modeM = 0; runA = 0; runB = 0; enA = 0; enB = 0; fA = 0; fB = 0;
    end else begin
      relA  = relAHi * 4 + relALo;
      wrapA = runA && tickIn && cntA == 1023;
      wrapB = runB && tickIn && cntB == 255;
      nA = !runA ? relA : (tickIn ? (wrapA ? relA : cntA + 1) : cntA);
      nB = !runB ? int'(relB) : (tickIn ? (wrapB ? int'(relB) : cntB + 1) : cntB);
      dataW = wrEn && portSel[0];
      ctrlW = dataW && !portSel[1] && lat0 == 8'h27;
      if (ctrlW && wrData[4]) fA = 0; else if (wrapA && enA) fA = 1;
      if (ctrlW && wrData[5]) fB = 0; else if (wrapB && enB) fB = 1;
      if (dataW) busyM = BUSY; else if (busyM > 0) busyM = busyM - 1;
      cntA = nA; cntB = nB;
      if (dataW && !portSel[1]) begin
        case (lat0)
          8'h24: relAHi = wrData;
          8'h25: relALo = wrData[1:0];
          8'h26: relB = wrData;
          8'h27: begin
            runA = wrData[0]; runB = wrData[1]; enA = wrData[2]; enB = wrData[3];
            modeM = wrData[7:6];
          end
          default: ;
        endcase
      end
      if (wrEn && !portSel[0]) begin
        if (portSel[1]) lat1 = wrData; else lat0 = wrData;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R8/R9 status byte vs model", rdData, {busyM > 0, 5'b0, fB, fA});
      chk("R10 irq vs model", irqOut, fA | fB);
      chk("R11 mode vs model", chanMode, modeM);
    end
  end

  task automatic wrAddr(bit bank, bit [7:0] a);
    @(negedge clk); wrEn = 1; portSel = {bank, 1'b0}; wrData = a;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic wrDat(bit bank, bit [7:0] d);
    @(negedge clk); wrEn = 1; portSel = {bank, 1'b1}; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic wrReg(bit [7:0] a, bit [7:0] d);
    wrAddr(0, a);
    wrDat(0, d);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1;
      @(negedge clk); tickIn = 0;
    end
  endtask

  initial begin
    #(200000 * 8);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    cmpOn = 1;
    @(negedge clk);
    chk("R1 reset status", rdData, 0);
    chk("R1 reset irq", irqOut, 0);
    chk("R1 reset mode", chanMode, 0);

    // R3: timer A reload 1020 -> overflow on 4th tick
    wrReg(8'h24, 8'hFF);
    wrReg(8'h25, 8'h00);
    wrReg(8'h27, 8'h05);
    chk("R9 busy right after write", rdData[7], 1);
    repeat (BUSY) @(negedge clk);
    chk("R9 busy dropped after BUSY_CYCLES", rdData[7], 0);
    ticks(3);
    chk("R3 no overflow before 1024-R ticks", rdData[0], 0);
    ticks(1);
    chk("R3 overflow on tick 1024-R", rdData[0], 1);
    chk("R10 irq follows flag", irqOut, 1);

    // R7: clear and no-effect
    wrReg(8'h27, 8'h15);
    chk("R7 clear bit clears flag A", rdData[0], 0);
    ticks(4);
    chk("R3 reload after overflow, second period", rdData[0], 1);
    wrReg(8'h27, 8'h05);
    chk("R7 zero in clear bit leaves flag", rdData[0], 1);

    // R3 low reload bits: reload 1022 -> 2 ticks
    wrReg(8'h27, 8'h10);
    wrReg(8'h25, 8'h02);
    wrReg(8'h27, 8'h05);
    ticks(1);
    chk("R3 low reload bits: tick 1 no flag", rdData[0], 0);
    ticks(1);
    chk("R3 low reload bits: tick 2 flag", rdData[0], 1);

    // R4/R6: timer B reload 250, flag disabled then enabled
    wrReg(8'h27, 8'h10);
    wrReg(8'h26, 8'hFA);
    wrReg(8'h27, 8'h02);
    ticks(6);
    chk("R6 disabled overflow leaves flag B", rdData[1], 0);
    wrReg(8'h27, 8'hC8);
    wrReg(8'h27, 8'hCA);
    chk("R11 mode field stored", chanMode, 3);
    ticks(5);
    chk("R4 no overflow before 256-R ticks", rdData[1], 0);
    ticks(1);
    chk("R4 overflow on tick 256-R", rdData[1], 1);

    // R5: stopped timers ignore ticks
    wrReg(8'h27, 8'h7C);
    chk("R7 both flags cleared", rdData[1:0], 0);
    ticks(300);
    chk("R5 stopped timers never overflow", rdData[1:0], 0);
    chk("R11 mode after write of 1", chanMode, 1);

    // R2: bank separation and address memory
    wrAddr(0, 8'h27);
    wrAddr(1, 8'h27);
    wrDat(1, 8'h3F);
    chk("R9 busy after bank 1 write", rdData[7], 1);
    ticks(300);
    chk("R2 bank 1 data write starts nothing", rdData[1:0], 0);
    chk("R2 bank 1 data write keeps mode", chanMode, 1);
    wrDat(0, 8'h05);
    ticks(2);
    chk("R2 bank 0 data went to remembered address", rdData[0], 1);

    // R7: clear coincides with overflow
    wrReg(8'h27, 8'h10);
    wrReg(8'h25, 8'h00);
    wrReg(8'h27, 8'h05);
    ticks(3);
    @(negedge clk); wrEn = 1; portSel = 2'b01; wrData = 8'h15; tickIn = 1;
    @(negedge clk); wrEn = 0; tickIn = 0;
    chk("R7 clear wins over simultaneous overflow", rdData[0], 0);
    ticks(3);
    chk("R3 running after coincident wrap", rdData[0], 0);
    ticks(1);
    chk("R3 period restored after coincident wrap", rdData[0], 1);

    repeat (8) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule